// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the byte-wide register front end of an SMBus host controller. Software reaches it through a one-byte register port with a write strobe and a read strobe. It holds a status byte, a control byte, a command byte, a target address byte, two data bytes, a block-data byte and a two-bit auxiliary control field. It clears status bits when ones are written to them, drives a level interrupt, and handles the start and kill commands.

When a transaction is launched, the block gives a downstream transaction engine a one-cycle start pulse. The decoded fields come out of the held registers at the same time: protocol, 7-bit target address, read flag, command, data bytes and option bits. The engine reports completion, device error, bus error and byte-done as one-cycle pulses, which set status bits. It can also write returned data into the two data registers. Launch has two paths. With interrupts enabled, the launch happens as soon as start is written. With interrupts disabled, only the busy flag is raised, and the launch waits until software next reads the status byte.

Top module: `smbhc_regs`

## Requirements
- R1: After reset the status byte reads 0x00, every register reads 0x00, irq is low, no launch is pending and xact_start is low.
- R2: A write to status offset 0x00 clears every bit of bits 7:1 that is written as one and leaves the other bits unchanged. Bit 0 (host busy) is never changed by a status write.
- R3: The control byte at offset 0x02 holds interrupt enable (bit 0), kill (bit 1), protocol (bits 4:2), last byte (bit 5), start (bit 6) and PEC enable (bit 7). Start is not stored. A control read returns only bits 4:0, with bits 7:5 as zero.
- R4: Writing control with start (bit 6) and interrupt enable (bit 0) both set gives one xact_start pulse in the cycle after the write. During that pulse xact_proto = control[4:2], xact_dev = address[7:1], xact_read = address[0], and xact_cmd, xact_data0 and xact_data1 equal the command byte (offset 0x03), data0 (offset 0x05) and data1 (offset 0x06). Host busy is not set.
- R5: Writing control with start set and interrupt enable clear sets host busy and gives no pulse. The next status read returns the old value with bit 0 set. That read clears host busy, and xact_start pulses in the following cycle.
- R6: When a launch would occur while device error (status bit 2) is set, no xact_start pulse is given and device error stays set.
- R7: A control write with kill (bit 1) set sets failed (status bit 4), clears host busy, cancels any pending deferred launch, and pulses xact_abort in the following cycle.
- R8: irq is high exactly when control bit 0 is set and any of status bits 7:1 is set. It is updated in the cycle after any access that changes either one.
- R9: Auxiliary control at offset 0x0D keeps only bits 1:0 (bit 0 PEC append, bit 1 block mode). Offsets other than 0x00, 0x02–0x07 and 0x0D read as 0x00, and writes to them change no register.
- R10: Each engine pulse sets its status bit: eng_done sets bit 1, eng_dev_err bit 2, eng_bus_err bit 3, eng_byte_done bit 7. eng_data_we[0] loads eng_data[7:0] into data0, and eng_data_we[1] loads eng_data[15:8] into data1.
- R11: The command (0x03), address (0x04), data0 (0x05), data1 (0x06) and block-data (0x07) registers read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Byte write strobe |
| reg_rd | input | 1 | Byte read strobe (reads with side effects act at the clock edge) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high, otherwise zero |
| irq | output | 1 | Level interrupt |
| xact_start | output | 1 | One-cycle launch pulse to the transaction engine |
| xact_abort | output | 1 | One-cycle kill pulse to the transaction engine |
| xact_proto | output | 3 | Protocol code from control bits 4:2 |
| xact_read | output | 1 | Read flag from address bit 0 |
| xact_dev | output | 7 | Target address from address bits 7:1 |
| xact_cmd | output | 8 | Command byte |
| xact_data0 | output | 8 | Data byte 0 |
| xact_data1 | output | 8 | Data byte 1 |
| xact_pec | output | 1 | PEC enable from control bit 7 |
| xact_last | output | 1 | Last-byte flag from control bit 5 |
| xact_aux | output | 2 | Auxiliary control bits 1:0 |
| eng_done | input | 1 | Engine completion pulse |
| eng_dev_err | input | 1 | Engine device-error pulse |
| eng_bus_err | input | 1 | Engine bus-error pulse |
| eng_byte_done | input | 1 | Engine byte-done pulse |
| eng_data_we | input | 2 | Write enables for returned data bytes 0 and 1 |
| eng_data | input | 16 | Returned data, byte 1 in bits 15:8 |

## Verification
The bench looks hardest at the deferred launch. A design that launched on the start write would give its pulse too early. A design that ignored the status read would never give one. A design that cleared busy before the read would return 0x00 instead of 0x01. The bench writes status with all ones while busy is set, which catches a design that lets software clear busy. It kills while a launch is pending, which catches a design that still launches on the next read. It launches while device error is set, which catches a design that issues a start pulse anyway. Control readback and auxiliary masking catch stored start bits or high bits that leak into reads. The unmapped offsets 0x01 and 0x0E catch a decoder that aliases them onto real registers.

// File: rtl/smbhc_pkg.sv
package smbhc_pkg;

    localparam int REG_W = 8;

    // register offsets (software-visible map)
    localparam int OFS_STS = 'h00;
    localparam int OFS_CTL = 'h02;
    localparam int OFS_CMD = 'h03;
    localparam int OFS_ADR = 'h04;
    localparam int OFS_DT0 = 'h05;
    localparam int OFS_DT1 = 'h06;
    localparam int OFS_BLK = 'h07;
    localparam int OFS_AUX = 'h0D;

    // status bit positions
    localparam int ST_BUSY   = 0;
    localparam int ST_INTR   = 1;
    localparam int ST_DEVERR = 2;
    localparam int ST_BUSERR = 3;
    localparam int ST_FAIL   = 4;
    localparam int ST_BYTE   = 7;

    // control bit positions
    localparam int CT_IEN   = 0;
    localparam int CT_KILL  = 1;
    localparam int CT_PLO   = 2;
    localparam int CT_LAST  = 5;
    localparam int CT_START = 6;
    localparam int CT_PEC   = 7;

    localparam logic [REG_W-1:0] CTL_RD_MASK  = 8'h1F;
    localparam logic [REG_W-1:0] AUX_KEEP     = 8'h03;
    localparam logic [REG_W-1:0] STS_W1C_MASK = 8'hFE;

    typedef struct packed {
        logic sts;
        logic ctl;
        logic cmd;
        logic adr;
        logic dt0;
        logic dt1;
        logic blk;
        logic aux;
    } regsel_t;

endpackage

// File: rtl/smbhc_decode.sv
module smbhc_decode
    import smbhc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output regsel_t           wsel,
    output regsel_t           rsel
);

    regsel_t hit;

    always_comb begin
        hit     = '0;
        hit.sts = (addr == ADDR_W'(OFS_STS));
        hit.ctl = (addr == ADDR_W'(OFS_CTL));
        hit.cmd = (addr == ADDR_W'(OFS_CMD));
        hit.adr = (addr == ADDR_W'(OFS_ADR));
        hit.dt0 = (addr == ADDR_W'(OFS_DT0));
        hit.dt1 = (addr == ADDR_W'(OFS_DT1));
        hit.blk = (addr == ADDR_W'(OFS_BLK));
        hit.aux = (addr == ADDR_W'(OFS_AUX));
    end

    assign wsel = wr ? hit : '0;
    assign rsel = rd ? hit : '0;

endmodule

// File: rtl/smbhc_launch.sv
module smbhc_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,   // control write with start set
    input  logic kill_wr,    // control write with kill set
    input  logic ien_wr,     // interrupt enable value in that write
    input  logic sts_rd,     // status read strobe
    input  logic dev_err,    // current device-error status bit
    output logic busy_set,
    output logic busy_clr,
    output logic go_q,
    output logic abort_q,
    output logic pending_q
);

    typedef struct packed {
        logic pending;
        logic go;
        logic abort;
    } lstate_t;

    lstate_t st_q, st_d;
    logic    try_go;

    always_comb begin
        st_d     = st_q;
        st_d.go  = 1'b0;
        busy_set = 1'b0;
        busy_clr = 1'b0;
        try_go   = 1'b0;

        if (start_wr) begin
            if (ien_wr) begin
                try_go = 1'b1;
            end else begin
                st_d.pending = 1'b1;
                busy_set     = 1'b1;
            end
        end else if (sts_rd && st_q.pending) begin
            st_d.pending = 1'b0;
            busy_clr     = 1'b1;
            try_go       = 1'b1;
        end

        if (kill_wr) begin
            st_d.pending = 1'b0;
            busy_clr     = 1'b1;
        end

        st_d.go    = try_go && !dev_err;
        st_d.abort = kill_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign go_q      = st_q.go;
    assign abort_q   = st_q.abort;
    assign pending_q = st_q.pending;

endmodule

// File: rtl/smbhc_status.sv
module smbhc_status
    import smbhc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             w1c_en,
    input  logic [REG_W-1:0] w1c_val,
    input  logic             busy_set,
    input  logic             busy_clr,
    input  logic             fail_set,
    input  logic             eng_done,
    input  logic             eng_dev_err,
    input  logic             eng_bus_err,
    input  logic             eng_byte_done,
    output logic [REG_W-1:0] stat_q
);

    typedef struct packed {
        logic [REG_W-1:0] stat;
    } sstate_t;

    sstate_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (w1c_en) s_d.stat = s_q.stat & ~(w1c_val & STS_W1C_MASK);
        if (eng_done)      s_d.stat[ST_INTR]   = 1'b1;
        if (eng_dev_err)   s_d.stat[ST_DEVERR] = 1'b1;
        if (eng_bus_err)   s_d.stat[ST_BUSERR] = 1'b1;
        if (eng_byte_done) s_d.stat[ST_BYTE]   = 1'b1;
        if (fail_set)      s_d.stat[ST_FAIL]   = 1'b1;
        if (busy_set)      s_d.stat[ST_BUSY]   = 1'b1;
        if (busy_clr)      s_d.stat[ST_BUSY]   = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_q = s_q.stat;

endmodule

// File: rtl/smbhc_regs.sv
module smbhc_regs
    import smbhc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              xact_start,
    output logic              xact_abort,
    output logic [2:0]        xact_proto,
    output logic              xact_read,
    output logic [6:0]        xact_dev,
    output logic [7:0]        xact_cmd,
    output logic [7:0]        xact_data0,
    output logic [7:0]        xact_data1,
    output logic              xact_pec,
    output logic              xact_last,
    output logic [1:0]        xact_aux,
    input  logic              eng_done,
    input  logic              eng_dev_err,
    input  logic              eng_bus_err,
    input  logic              eng_byte_done,
    input  logic [1:0]        eng_data_we,
    input  logic [15:0]       eng_data
);

    typedef struct packed {
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] cmd;
        logic [REG_W-1:0] adr;
        logic [REG_W-1:0] dt0;
        logic [REG_W-1:0] dt1;
        logic [REG_W-1:0] blk;
        logic [REG_W-1:0] aux;
    } cfg_t;

    cfg_t             cfg_q, cfg_d;
    regsel_t          wsel, rsel;
    logic [REG_W-1:0] stat_q;
    logic             busy_set, busy_clr, go_q, abort_q, pending_q;
    logic             start_wr, kill_wr;

    smbhc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .wr   (reg_wr),
        .rd   (reg_rd),
        .wsel (wsel),
        .rsel (rsel)
    );

    assign start_wr = wsel.ctl && reg_wdata[CT_START];
    assign kill_wr  = wsel.ctl && reg_wdata[CT_KILL];

    smbhc_launch u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .kill_wr   (kill_wr),
        .ien_wr    (reg_wdata[CT_IEN]),
        .sts_rd    (rsel.sts),
        .dev_err   (stat_q[ST_DEVERR]),
        .busy_set  (busy_set),
        .busy_clr  (busy_clr),
        .go_q      (go_q),
        .abort_q   (abort_q),
        .pending_q (pending_q)
    );

    smbhc_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .w1c_en        (wsel.sts),
        .w1c_val       (reg_wdata),
        .busy_set      (busy_set),
        .busy_clr      (busy_clr),
        .fail_set      (kill_wr),
        .eng_done      (eng_done),
        .eng_dev_err   (eng_dev_err),
        .eng_bus_err   (eng_bus_err),
        .eng_byte_done (eng_byte_done),
        .stat_q        (stat_q)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wsel.ctl) begin
            cfg_d.ctl           = reg_wdata;
            cfg_d.ctl[CT_START] = 1'b0;
        end
        if (wsel.cmd) cfg_d.cmd = reg_wdata;
        if (wsel.adr) cfg_d.adr = reg_wdata;
        if (wsel.dt0) cfg_d.dt0 = reg_wdata;
        if (wsel.dt1) cfg_d.dt1 = reg_wdata;
        if (wsel.blk) cfg_d.blk = reg_wdata;
        if (wsel.aux) cfg_d.aux = reg_wdata & AUX_KEEP;
        if (eng_data_we[0]) cfg_d.dt0 = eng_data[7:0];
        if (eng_data_we[1]) cfg_d.dt1 = eng_data[15:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (1'b1)
            rsel.sts: reg_rdata = stat_q;
            rsel.ctl: reg_rdata = cfg_q.ctl & CTL_RD_MASK;
            rsel.cmd: reg_rdata = cfg_q.cmd;
            rsel.adr: reg_rdata = cfg_q.adr;
            rsel.dt0: reg_rdata = cfg_q.dt0;
            rsel.dt1: reg_rdata = cfg_q.dt1;
            rsel.blk: reg_rdata = cfg_q.blk;
            rsel.aux: reg_rdata = cfg_q.aux;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq        = cfg_q.ctl[CT_IEN] && (|stat_q[REG_W-1:1]);
    assign xact_start = go_q;
    assign xact_abort = abort_q;
    assign xact_proto = cfg_q.ctl[CT_PLO+2:CT_PLO];
    assign xact_read  = cfg_q.adr[0];
    assign xact_dev   = cfg_q.adr[7:1];
    assign xact_cmd   = cfg_q.cmd;
    assign xact_data0 = cfg_q.dt0;
    assign xact_data1 = cfg_q.dt1;
    assign xact_pec   = cfg_q.ctl[CT_PEC];
    assign xact_last  = cfg_q.ctl[CT_LAST];
    assign xact_aux   = cfg_q.aux[1:0];

endmodule

// File: rtl/smbhc_regs_chk.sv
module smbhc_regs_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              irq,
    input logic              xact_start,
    input logic              xact_abort,
    input logic [7:0]        stat_q,
    input logic              pending_q,
    input logic              eng_any
);

    // R2: a status write never moves host busy
    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == ADDR_W'(0)) |=> (stat_q[0] == $past(stat_q[0])));

    // R3: control readback never shows bits 7:5
    assert_ctl_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(2)) |-> (reg_rdata[7:5] == 3'b000));

    // R5: deferred start raises busy and holds off the pulse
    assert_defer_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == ADDR_W'(2) && reg_wdata[6] && !reg_wdata[0] && !reg_wdata[1])
        |=> (stat_q[0] && pending_q && !xact_start));

    // R6: no launch pulse while device error was standing
    assert_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xact_start |-> !$past(stat_q[2]));

    // R7: kill sets failed, drops busy and pulses abort
    assert_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == ADDR_W'(2) && reg_wdata[1])
        |=> (stat_q[4] && !stat_q[0] && xact_abort && !pending_q));

    // R8: clearing all clearable status bits drops the interrupt
    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == ADDR_W'(0) && reg_wdata == 8'hFE && !eng_any) |=> !irq);

endmodule

bind smbhc_regs smbhc_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .xact_start(xact_start),
    .xact_abort(xact_abort),
    .stat_q    (stat_q),
    .pending_q (pending_q),
    .eng_any   (eng_done | eng_dev_err | eng_bus_err | eng_byte_done)
);

// File: tb/smbhc_regs_bench.sv
module smbhc_regs_bench;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          irq, xact_start, xact_abort, xact_read, xact_pec, xact_last;
    logic [2:0]    xact_proto;
    logic [6:0]    xact_dev;
    logic [7:0]    xact_cmd, xact_data0, xact_data1;
    logic [1:0]    xact_aux;
    logic          eng_done = 1'b0, eng_dev_err = 1'b0, eng_bus_err = 1'b0, eng_byte_done = 1'b0;
    logic [1:0]    eng_data_we = '0;
    logic [15:0]   eng_data = '0;

    int  n_chk = 0, n_bad = 0;
    bit  finished = 1'b0;
    logic seen_start, seen_abort;
    logic [7:0] rd_val;

    always #10 clk = ~clk;

    smbhc_regs #(.ADDR_W(AW)) u_smbhc_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .xact_start(xact_start), .xact_abort(xact_abort), .xact_proto(xact_proto),
        .xact_read(xact_read), .xact_dev(xact_dev), .xact_cmd(xact_cmd),
        .xact_data0(xact_data0), .xact_data1(xact_data1), .xact_pec(xact_pec),
        .xact_last(xact_last), .xact_aux(xact_aux),
        .eng_done(eng_done), .eng_dev_err(eng_dev_err), .eng_bus_err(eng_bus_err),
        .eng_byte_done(eng_byte_done), .eng_data_we(eng_data_we), .eng_data(eng_data)
    );

    typedef struct packed {
        logic [1:0] op;   // 1 write, 2 read and compare
        logic [5:0] a;
        logic [7:0] d;
        logic [7:0] e;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 6'h03, 8'hA5, 8'h00}, '{2'd2, 6'h03, 8'h00, 8'hA5},   // R11
        '{2'd1, 6'h04, 8'h5B, 8'h00}, '{2'd2, 6'h04, 8'h00, 8'h5B},   // R11
        '{2'd1, 6'h05, 8'h11, 8'h00}, '{2'd2, 6'h05, 8'h00, 8'h11},   // R11
        '{2'd1, 6'h06, 8'h22, 8'h00}, '{2'd2, 6'h06, 8'h00, 8'h22},   // R11
        '{2'd1, 6'h07, 8'hC3, 8'h00}, '{2'd2, 6'h07, 8'h00, 8'hC3},   // R11
        '{2'd1, 6'h0D, 8'hFF, 8'h00}, '{2'd2, 6'h0D, 8'h00, 8'h03},   // R9
        '{2'd1, 6'h01, 8'h77, 8'h00}, '{2'd2, 6'h01, 8'h00, 8'h00},   // R9
        '{2'd1, 6'h0E, 8'h55, 8'h00}, '{2'd2, 6'h0E, 8'h00, 8'h00},   // R9
        '{2'd1, 6'h02, 8'hBC, 8'h00}, '{2'd2, 6'h02, 8'h00, 8'h1C},   // R3
        '{2'd2, 6'h00, 8'h00, 8'h00}, '{2'd1, 6'h02, 8'h00, 8'h00}    // R3 status untouched
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        seen_start = xact_start; seen_abort = xact_abort;
    endtask

    task automatic rd(input logic [5:0] a);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #5 rd_val = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        seen_start = xact_start; seen_abort = xact_abort;
    endtask

    task automatic eng(input logic dn, input logic de, input logic be, input logic bd,
                       input logic [1:0] we, input logic [15:0] dat);
        @(negedge clk);
        eng_done = dn; eng_dev_err = de; eng_bus_err = be; eng_byte_done = bd;
        eng_data_we = we; eng_data = dat;
        @(negedge clk);
        eng_done = 0; eng_dev_err = 0; eng_bus_err = 0; eng_byte_done = 0; eng_data_we = '0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 start", {15'd0, xact_start}, 16'd0);
        rd(6'h00); chk("R1 status", {8'd0, rd_val}, 16'h0000);
        chk("R1 no pending launch", {15'd0, seen_start}, 16'd0);
        rd(6'h05); chk("R1 data0", {8'd0, rd_val}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op == 2'd1) wr(VECS[i].a, VECS[i].d);
            else begin
                rd(VECS[i].a);
                chk($sformatf("R11/R9/R3 vec %0d", i), {8'd0, rd_val}, {8'd0, VECS[i].e});
            end
        end

        // R4 immediate launch: addr 0x5B, cmd A5, d0 11, d1 22 already held; aux 3
        wr(6'h02, 8'hED);  // start, pec, proto 3, ien
        chk("R4 pulse", {15'd0, seen_start}, 16'd1);
        chk("R4 proto", {13'd0, xact_proto}, 16'd3);
        chk("R4 dev", {9'd0, xact_dev}, 16'h002D);
        chk("R4 read", {15'd0, xact_read}, 16'd1);
        chk("R4 cmd/data", {xact_cmd, xact_data0}, 16'hA511);
        chk("R4 data1", {8'd0, xact_data1}, 16'h0022);
        chk("R4 pec/last/aux", {12'd0, xact_pec, xact_last, xact_aux}, 16'h000F);
        @(negedge clk);
        chk("R4 single pulse", {15'd0, xact_start}, 16'd0);
        rd(6'h00); chk("R4 busy not set", {8'd0, rd_val}, 16'h0000);

        // R10 completion and returned data; R8 irq with enable
        eng(1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 16'hBEEF);
        chk("R8 irq on intr", {15'd0, irq}, 16'd1);
        rd(6'h00); chk("R10 intr bit", {8'd0, rd_val}, 16'h0002);
        rd(6'h05); chk("R10 data0 load", {8'd0, rd_val}, 16'h00EF);
        rd(6'h06); chk("R10 data1 load", {8'd0, rd_val}, 16'h00BE);

        // R2 write-one-to-clear
        wr(6'h00, 8'h00); rd(6'h00); chk("R2 zero write keeps", {8'd0, rd_val}, 16'h0002);
        wr(6'h00, 8'hFF); rd(6'h00); chk("R2 clear", {8'd0, rd_val}, 16'h0000);
        chk("R8 irq drop", {15'd0, irq}, 16'd0);

        // R5 deferred launch
        wr(6'h02, 8'h48);
        chk("R5 no early pulse", {15'd0, seen_start}, 16'd0);
        rd(6'h00);
        chk("R5 read shows busy", {8'd0, rd_val}, 16'h0001);
        chk("R5 pulse after read", {15'd0, seen_start}, 16'd1);
        chk("R5 proto", {13'd0, xact_proto}, 16'd2);
        rd(6'h00); chk("R5 busy cleared", {8'd0, rd_val}, 16'h0000);
        chk("R5 one pulse only", {15'd0, seen_start}, 16'd0);

        // R2 busy survives all-ones status write
        wr(6'h02, 8'h40);
        wr(6'h00, 8'hFF);
        rd(6'h00); chk("R2 busy kept", {8'd0, rd_val}, 16'h0001);
        chk("R5 launch on read", {15'd0, seen_start}, 16'd1);

        // R7 kill cancels pending launch
        wr(6'h02, 8'h40);
        wr(6'h02, 8'h02);
        chk("R7 abort pulse", {15'd0, seen_abort}, 16'd1);
        rd(6'h00); chk("R7 failed, busy clear", {8'd0, rd_val}, 16'h0010);
        chk("R7 no launch", {15'd0, seen_start}, 16'd0);
        chk("R8 no irq, enable off", {15'd0, irq}, 16'd0);
        wr(6'h00, 8'hFF);

        // R6 refusal with device error
        eng(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 16'h0000);
        wr(6'h02, 8'h41);
        chk("R6 no pulse", {15'd0, seen_start}, 16'd0);
        rd(6'h00); chk("R6 dev err stays", {8'd0, rd_val}, 16'h0004);
        chk("R8 irq dev err", {15'd0, irq}, 16'd1);
        wr(6'h02, 8'h00);
        chk("R8 irq gated", {15'd0, irq}, 16'd0);
        wr(6'h00, 8'hFF);

        // R10 bus error and byte done
        eng(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 16'h0000);
        rd(6'h00); chk("R10 bus/byte bits", {8'd0, rd_val}, 16'h0088);
        wr(6'h00, 8'h80);
        rd(6'h00); chk("R2 partial clear", {8'd0, rd_val}, 16'h0008);

        // R7 kill with enable raises irq
        wr(6'h00, 8'hFF);
        wr(6'h02, 8'h03);
        chk("R7 abort with ien", {15'd0, seen_abort}, 16'd1);
        chk("R8 irq on failed", {15'd0, irq}, 16'd1);
        rd(6'h02); chk("R3 ctl readback", {8'd0, rd_val}, 16'h0003);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule